// File: doc/BRIEF.md
# Line Prefetch Execution Unit

This unit carries out a cache-line prefetch operation in one pipeline slot. It takes a decoded operation (addressing form, faulting or non-faulting type, exclusive flag, 2-bit locality hint) together with a base register value, an index register value and a 9-bit immediate. Each register arrives with its poison bit, which marks a deferred exception. It also takes two attributes of the page being touched: whether it is cacheable and whether the address is implemented.

From these it produces up to four results. A primary prefetch request goes out for the line that holds the original base address. A writeback returns the post-incremented base and its poison bit. A second, droppable hint request goes out for the line at the incremented address. A fault pulse signals an unimplemented data address. All results are registered, so they appear one cycle after the operation is accepted.

Only a primary request that the memory side has not yet taken can hold the unit. An untaken hint waits until the next accepted operation replaces it, and it never holds back new operations.

Top module: `lfetch_unit`

## Requirements
- R1: After reset, `op_ready` is 1 and `req_valid`, `hint_valid`, `wb_valid` and `fault_valid` are all 0.
- R2: The form encoding is 00 for no update, 01 for index-register update and 10 for immediate update; 11 behaves as 00. For an accepted update-form operation that does not fault, `wb_valid` pulses for one cycle. `wb_value` is then the base plus the index value (form 01) or the base plus the sign-extended 9-bit immediate (form 10). Form 00 never asserts `wb_valid`.
- R3: A primary request carries the original, pre-increment base with its low log2(`LINE_BYTES`) bits cleared. `req_hint` and `req_excl` are copies of the operation's hint and exclusive flag.
- R4: `wb_nat` is the base poison bit ORed with the index poison bit, and the index poison bit counts only in form 01. A poisoned index never causes a fault.
- R5: When the base poison bit is set, no primary request, no hint request and no fault are produced. The update forms still write back the incremented base.
- R6: A non-cacheable page suppresses the primary request but causes no fault. The writeback and hint request still occur.
- R7: A faulting-type operation (`op_faulting`=1) on an unimplemented address with a clean base pulses `fault_valid` for one cycle and produces no request, no hint and no writeback. The non-faulting type on such an address produces no fault and no primary request, but still writes back.
- R8: An update-form operation with a clean base that does not fault raises `hint_valid`. `hint_addr` is then the incremented base aligned down to the line, and `hint_hint` and `hint_excl` equal the operation's values. Form 00 raises no hint.
- R9: While `req_valid` is 1 and `req_ready` is 0, the request and its address are held and `op_ready` is 0. A new operation is accepted in the same cycle that the pending request is taken.
- R10: A hint that is not taken (`hint_ready`=0) stays valid and unchanged until it is taken or until the next accepted operation replaces it. A pending hint never lowers `op_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Operation accepted when high together with op_valid |
| op_form | input | 2 | Addressing form (00 none, 01 index, 10 immediate) |
| op_faulting | input | 1 | 1 = faulting type, 0 = non-faulting type |
| op_excl | input | 1 | Request exclusive ownership of the line |
| op_hint | input | 2 | Locality hint, passed through unchanged |
| base_val | input | AW | Base register value |
| base_nat | input | 1 | Base register poison bit |
| idx_val | input | AW | Index register value |
| idx_nat | input | 1 | Index register poison bit |
| imm9 | input | 9 | Signed immediate increment |
| page_cacheable | input | 1 | Page attribute: cacheable |
| addr_implemented | input | 1 | Base address lies in the implemented range |
| wb_valid | output | 1 | Base writeback strobe |
| wb_value | output | AW | Post-incremented base |
| wb_nat | output | 1 | Poison bit of the written-back base |
| req_valid | output | 1 | Primary prefetch request valid |
| req_ready | input | 1 | Primary request taken |
| req_addr | output | AW | Line-aligned prefetch address |
| req_hint | output | 2 | Locality hint of the request |
| req_excl | output | 1 | Exclusive flag of the request |
| hint_valid | output | 1 | Post-increment hint request valid |
| hint_ready | input | 1 | Hint request taken |
| hint_addr | output | AW | Line-aligned incremented address |
| hint_hint | output | 2 | Locality hint of the hint request |
| hint_excl | output | 1 | Exclusive flag of the hint request |
| fault_valid | output | 1 | Unimplemented data address fault pulse |

## Verification
Every result is due exactly one cycle after the clock edge that accepts the operation. The bench therefore drives inputs on the falling edge and reads the outputs one time unit after the next rising edge. For a request held by a low `req_ready`, or a hint held by a low `hint_ready`, the bench reads again after each following rising edge. It also checks that `op_ready` is low before the edge in which a stalled operation would otherwise be taken. In the stall case the waiting operation is taken in the edge that releases the pending request, so its results are checked one cycle after that edge.

// File: rtl/lfetch_unit.sv
module lfetch_unit #(
  parameter int AW         = 64,
  parameter int LINE_BYTES = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic [1:0]    op_form,
  input  logic          op_faulting,
  input  logic          op_excl,
  input  logic [1:0]    op_hint,
  input  logic [AW-1:0] base_val,
  input  logic          base_nat,
  input  logic [AW-1:0] idx_val,
  input  logic          idx_nat,
  input  logic [8:0]    imm9,
  input  logic          page_cacheable,
  input  logic          addr_implemented,
  output logic          wb_valid,
  output logic [AW-1:0] wb_value,
  output logic          wb_nat,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic [1:0]    req_hint,
  output logic          req_excl,
  output logic          hint_valid,
  input  logic          hint_ready,
  output logic [AW-1:0] hint_addr,
  output logic [1:0]    hint_hint,
  output logic          hint_excl,
  output logic          fault_valid
);
  localparam int OFS = $clog2(LINE_BYTES);
  localparam logic [1:0] FORM_IDX = 2'b01;
  localparam logic [1:0] FORM_IMM = 2'b10;

  if (LINE_BYTES < 32 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
    $error("LINE_BYTES must be a power of two of at least 32");
  end

  function automatic logic [AW-1:0] line_of(input logic [AW-1:0] a);
    return {a[AW-1:OFS], {OFS{1'b0}}};
  endfunction

  logic          upd, flt, go_req, go_hint, accept;
  logic [AW-1:0] incr, next_base;

  assign upd       = (op_form == FORM_IDX) || (op_form == FORM_IMM);
  assign incr      = (op_form == FORM_IDX) ? idx_val : {{(AW-9){imm9[8]}}, imm9};
  assign next_base = base_val + incr;
  assign flt       = op_faulting && !addr_implemented && !base_nat;
  assign go_req    = !base_nat && page_cacheable && addr_implemented;
  assign go_hint   = upd && !base_nat && !flt;
  assign op_ready  = !req_valid || req_ready;
  assign accept    = op_valid && op_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid    <= 1'b0;
      fault_valid <= 1'b0;
      req_valid   <= 1'b0;
      hint_valid  <= 1'b0;
      wb_value    <= '0;
      wb_nat      <= 1'b0;
      req_addr    <= '0;
      req_hint    <= '0;
      req_excl    <= 1'b0;
      hint_addr   <= '0;
      hint_hint   <= '0;
      hint_excl   <= 1'b0;
    end else begin
      wb_valid    <= accept && upd && !flt;
      fault_valid <= accept && flt;
      req_valid   <= accept ? go_req  : (req_valid && !req_ready);
      hint_valid  <= accept ? go_hint : (hint_valid && !hint_ready);
      if (accept) begin
        wb_value <= next_base;
        wb_nat   <= base_nat | ((op_form == FORM_IDX) & idx_nat);
      end
      if (accept && go_req) begin
        req_addr <= line_of(base_val);
        req_hint <= op_hint;
        req_excl <= op_excl;
      end
      if (accept && go_hint) begin
        hint_addr <= line_of(next_base);
        hint_hint <= op_hint;
        hint_excl <= op_excl;
      end
    end
  end
endmodule

module lfetch_unit_chk #(
  parameter int AW  = 64,
  parameter int OFS = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic          op_ready,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          hint_valid,
  input logic          hint_ready,
  input logic [AW-1:0] hint_addr,
  input logic          wb_valid,
  input logic          fault_valid
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr)); // R9
  AST_HINT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    hint_valid && !hint_ready && !(op_valid && op_ready) |=> hint_valid && $stable(hint_addr)); // R10
  AST_HINT_NO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    hint_valid && !req_valid |-> op_ready); // R10
  AST_FAULT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> !wb_valid && !hint_valid && !req_valid); // R7
  AST_FAULT_FROM_OP: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> $past(op_valid && op_ready)); // R7
  AST_WB_FROM_OP: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> $past(op_valid && op_ready)); // R2
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[OFS-1:0] == '0); // R3
endmodule

bind lfetch_unit lfetch_unit_chk #(.AW(AW), .OFS(OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
  .hint_valid(hint_valid), .hint_ready(hint_ready), .hint_addr(hint_addr),
  .wb_valid(wb_valid), .fault_valid(fault_valid)
);

// File: tb/lfetch_unit_bench.sv
module lfetch_unit_bench;
  localparam int CLK_P = 10;
  localparam int AW = 64;
  localparam int LB = 64;

  logic clk = 0, rst_n = 0;
  logic op_valid = 0, op_ready;
  logic [1:0] op_form = 0, op_hint = 0;
  logic op_faulting = 0, op_excl = 0;
  logic [AW-1:0] base_val = 0, idx_val = 0;
  logic base_nat = 0, idx_nat = 0;
  logic [8:0] imm9 = 0;
  logic page_cacheable = 1, addr_implemented = 1;
  logic wb_valid, wb_nat, req_valid, req_excl, hint_valid, hint_excl, fault_valid;
  logic [AW-1:0] wb_value, req_addr, hint_addr;
  logic [1:0] req_hint, hint_hint;
  logic req_ready = 1, hint_ready = 1;

  int checks = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  lfetch_unit #(.AW(AW), .LINE_BYTES(LB)) u_lfetch_unit (.*);

  function automatic logic [AW-1:0] align(input logic [AW-1:0] a);
    return a & ~(AW'(LB) - 1);
  endfunction

  function automatic logic [AW-1:0] sext9(input logic [8:0] v);
    return {{(AW-9){v[8]}}, v};
  endfunction

  task automatic chk(input string r, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", r, what, act, exp);
    end
  endtask

  task automatic do_op(input string r, input logic [1:0] f, input logic fl, input logic ex,
                       input logic [1:0] h, input logic [AW-1:0] b, input logic bn,
                       input logic [AW-1:0] ix, input logic inn, input logic [8:0] im,
                       input logic c, input logic impl);
    logic upd, flt, ereq, ehint, ewb;
    logic [AW-1:0] nb;
    upd   = (f == 2'b01) || (f == 2'b10);
    nb    = b + ((f == 2'b01) ? ix : sext9(im));
    flt   = fl && !impl && !bn;
    ereq  = !bn && c && impl;
    ehint = upd && !bn && !flt;
    ewb   = upd && !flt;
    @(negedge clk);
    req_ready = 1; hint_ready = 1;
    op_valid = 1; op_form = f; op_faulting = fl; op_excl = ex; op_hint = h;
    base_val = b; base_nat = bn; idx_val = ix; idx_nat = inn; imm9 = im;
    page_cacheable = c; addr_implemented = impl;
    @(posedge clk); #1;
    op_valid = 0;
    chk(r, "wb_valid", AW'(wb_valid), AW'(ewb));
    if (ewb) begin
      chk(r, "wb_value", wb_value, nb);
      chk(r, "wb_nat", AW'(wb_nat), AW'(bn | ((f == 2'b01) & inn)));
    end
    chk(r, "fault_valid", AW'(fault_valid), AW'(flt));
    chk(r, "req_valid", AW'(req_valid), AW'(ereq));
    if (ereq) begin
      chk(r, "req_addr", req_addr, align(b));
      chk(r, "req_hint", AW'(req_hint), AW'(h));
      chk(r, "req_excl", AW'(req_excl), AW'(ex));
    end
    chk(r, "hint_valid", AW'(hint_valid), AW'(ehint));
    if (ehint) begin
      chk(r, "hint_addr", hint_addr, align(nb));
      chk(r, "hint_hint", AW'(hint_hint), AW'(h));
      chk(r, "hint_excl", AW'(hint_excl), AW'(ex));
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "op_ready", AW'(op_ready), 1);
    chk("R1", "req_valid", AW'(req_valid), 0);
    chk("R1", "hint_valid", AW'(hint_valid), 0);
    chk("R1", "wb_valid", AW'(wb_valid), 0);
    chk("R1", "fault_valid", AW'(fault_valid), 0);
    @(negedge clk); rst_n = 1;

    do_op("R2", 2'b10, 1, 0, 2'd1, 64'h1000, 0, 0, 0, 9'h1F0, 1, 1);
    do_op("R2", 2'b01, 1, 0, 2'd2, 64'h2345, 0, 64'h100, 0, 0, 1, 1);
    do_op("R8", 2'b00, 1, 0, 2'd0, 64'h3333, 0, 64'h40, 0, 9'h10, 1, 1);
    do_op("R8", 2'b11, 0, 1, 2'd3, 64'h4444, 0, 64'h40, 0, 9'h10, 1, 1);
    do_op("R3", 2'b10, 0, 1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, 9'h0FF, 1, 1);
    do_op("R4", 2'b01, 1, 0, 2'd0, 64'h5000, 0, 64'h80, 1, 0, 1, 1);
    do_op("R4", 2'b10, 0, 0, 2'd0, 64'h5000, 0, 64'h80, 1, 9'h20, 1, 1);
    do_op("R5", 2'b10, 1, 0, 2'd1, 64'h6000, 1, 0, 0, 9'h40, 1, 1);
    do_op("R5", 2'b01, 1, 0, 2'd1, 64'h6000, 1, 64'h8, 0, 0, 1, 0);
    do_op("R6", 2'b10, 1, 1, 2'd2, 64'h7000, 0, 0, 0, 9'h40, 0, 1);
    do_op("R6", 2'b00, 1, 0, 2'd2, 64'h7000, 0, 0, 0, 0, 0, 1);
    do_op("R7", 2'b10, 1, 0, 2'd0, 64'h8000, 0, 0, 0, 9'h40, 1, 0);
    do_op("R7", 2'b01, 0, 0, 2'd0, 64'h8000, 0, 64'h40, 0, 0, 1, 0);
    do_op("R7", 2'b00, 1, 0, 2'd0, 64'h8000, 0, 0, 0, 0, 0, 0);

    // R9: stalled primary request
    @(negedge clk);
    req_ready = 0; op_valid = 1; op_form = 2'b00; op_faulting = 0; base_nat = 0;
    page_cacheable = 1; addr_implemented = 1; base_val = 64'hA0C0;
    @(posedge clk); #1;
    chk("R9", "req_valid", AW'(req_valid), 1);
    chk("R9", "req_addr", req_addr, 64'hA0C0);
    @(negedge clk);
    base_val = 64'hB0F3; op_form = 2'b10; imm9 = 9'h8;
    chk("R9", "op_ready", AW'(op_ready), 0);
    @(posedge clk); #1;
    chk("R9", "req_valid held", AW'(req_valid), 1);
    chk("R9", "req_addr held", req_addr, 64'hA0C0);
    chk("R9", "wb_valid", AW'(wb_valid), 0);
    @(negedge clk); req_ready = 1;
    @(posedge clk); #1;
    op_valid = 0;
    chk("R9", "req_addr next", req_addr, 64'hB0C0);
    chk("R9", "wb_value", wb_value, 64'hB0FB);

    // R10: untaken hint waits, then is replaced
    @(negedge clk);
    hint_ready = 0; op_valid = 1; op_form = 2'b01; base_val = 64'h1_0000; idx_val = 64'h1234; idx_nat = 0;
    @(posedge clk); #1;
    op_valid = 0;
    chk("R10", "hint_valid", AW'(hint_valid), 1);
    chk("R10", "hint_addr", hint_addr, 64'h1_1200);
    repeat (2) begin
      @(posedge clk); #1;
      chk("R10", "hint held", AW'(hint_valid), 1);
      chk("R10", "hint_addr held", hint_addr, 64'h1_1200);
      chk("R10", "op_ready", AW'(op_ready), 1);
    end
    @(negedge clk);
    op_valid = 1; op_form = 2'b00;
    @(posedge clk); #1;
    op_valid = 0;
    chk("R10", "hint replaced", AW'(hint_valid), 0);
    @(negedge clk); hint_ready = 1;

    for (int i = 0; i < 400; i++) begin
      logic [1:0] f;
      f = 2'($urandom_range(0, 3));
      do_op("R2", f, 1'($urandom), 1'($urandom), 2'($urandom),
            {$urandom, $urandom}, ($urandom_range(0, 7) == 0), {$urandom, $urandom},
            ($urandom_range(0, 5) == 0), 9'($urandom), ($urandom_range(0, 4) != 0),
            ($urandom_range(0, 4) != 0));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule